// File: doc/BRIEF.md
# Pattern-Locked Sine Synthesizer

This block generates a sine wave as a stream of 14-bit offset-binary codes for an external DAC. The sine can stand in for the square-pulse source as the drive signal of a high-voltage amplifier. A 32-bit phase accumulator advances by a host-programmed tuning word on every clock. The top bits of the phase address a quarter-wave sine table, and the other three quarters of the cycle are produced from it by mirroring and sign inversion.

To keep the sine in step with the pattern sequencer's timing diagram, one bit of the sequencer output drives the `sync_in` input. On each rising edge of that bit the accumulator is reloaded with a programmable phase offset. A new tuning word is held in a staging register and only becomes active at a point where the change cannot glitch the waveform: the next sync edge, or the next wrap of the accumulator. While disabled, the block outputs mid-scale and holds its phase at the offset, so it starts from a known phase when enabled.

Top module: `sine_sync_dds`

## Requirements
- R1: While reset is high, and on the cycle after it, `dac_code` is mid-scale 0x2000 and the block is disabled.
- R2: While disabled (control bit 0 = 0), `dac_code` is 0x2000 and the accumulator holds the phase offset register.
- R3: While enabled with no sync edge, the accumulator advances by the active tuning word every clock (modulo 2^32). The code for accumulator value A appears on `dac_code` two clocks later.
- R4: The code for phase index p = A[31:22] (0..1023) is 8192 + round(8191·sin(2π(p+0.5)/1024)), rounded half away from zero. It is built from a 256-entry quarter table: bit 30 mirrors the index and bit 31 negates the magnitude.
- R5: A rising edge on `sync_in` (low on the previous clock, high now) while enabled loads the accumulator with the phase offset register. The code for that offset appears two clocks later. A level held high, or a falling edge, has no effect.
- R6: A tuning word write goes to a staging register. It becomes active only at a sync rising edge, at a carry out of the accumulator's top bit, or while disabled.
- R7: With a constant tuning word T and no sync edges, the number of upward mid-scale crossings over N clocks is within 1 of T·N/2^32.
- R8: Host writes decode on `cfg_addr`: 0 writes the tuning word, 1 writes the phase offset, 2 writes control (bit 0 = enable). Address 3 is ignored.
- R9: After enable is written, the first code taken from the offset phase appears two clocks after the write edge. Each later code follows the R3 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Host register write strobe |
| cfg_addr | input | 2 | Host register select |
| cfg_wdata | input | 32 | Host write data |
| sync_in | input | 1 | Pattern sequencer bit used as phase sync |
| dac_code | output | 14 | Offset-binary sample to the DAC |

## Verification
A corrupted accumulator or staged tuning word shows up as a wrong code on `dac_code` exactly two clocks after the affected clock, and it keeps repeating until the next sync edge reloads the phase. The bench therefore compares every sample against a model built from the requirements. Errors in table mirroring or sign appear within one quarter of a sine period, and a full index sweep exposes them all. A missed or misplaced sync reload shows as a wrong code on the second clock after the edge. A tuning word applied too early or too late shows as a phase slip on the first sample past the wrap.

// File: rtl/sdds_pkg.sv
`timescale 1ns/1ps
package sdds_pkg;
  // host register selects; address 3 decodes to nothing
  typedef enum logic [1:0] {
    SEL_TUNE = 2'd0,
    SEL_OFFS = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } sdds_sel_e;
endpackage

// File: rtl/sdds_regs.sv
`timescale 1ns/1ps
module sdds_regs #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [ACC_W-1:0] wdata,
  output logic [ACC_W-1:0] tune_pend,
  output logic [ACC_W-1:0] offs,
  output logic             run
);
  import sdds_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      tune_pend <= '0;
      offs      <= '0;
      run       <= 1'b0;
    end else if (we) begin
      case (sdds_sel_e'(addr))
        SEL_TUNE: tune_pend <= wdata;
        SEL_OFFS: offs      <= wdata;
        SEL_CTRL: run       <= wdata[0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/sdds_phase.sv
`timescale 1ns/1ps
module sdds_phase #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sync_in,
  input  logic [ACC_W-1:0] tune_pend,
  input  logic [ACC_W-1:0] offs,
  output logic [ACC_W-1:0] acc,
  output logic [ACC_W-1:0] tune_act,
  output logic             sync_rise,
  output logic             wrap
);
  logic           sync_q;
  logic [ACC_W:0] sum;

  always_comb begin
    sync_rise = sync_in & ~sync_q;
    sum       = {1'b0, acc} + {1'b0, tune_act};
    wrap      = run & ~sync_rise & sum[ACC_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= 1'b0;
      acc      <= '0;
      tune_act <= '0;
    end else begin
      sync_q <= sync_in;
      if (!run || sync_rise) begin
        acc      <= offs;
        tune_act <= tune_pend;
      end else begin
        acc <= sum[ACC_W-1:0];
        if (sum[ACC_W]) tune_act <= tune_pend;
      end
    end
  end
endmodule

// File: rtl/sdds_lut.sv
`timescale 1ns/1ps
module sdds_lut #(
  parameter int PH_W  = 10,
  parameter int DAC_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PH_W-1:0]  phase,
  output logic [DAC_W-1:0] dac_code
);
  localparam int QA_W  = PH_W - 2;
  localparam int QN    = 1 << QA_W;
  localparam int MAG_W = DAC_W - 1;
  localparam int AMP   = (1 << MAG_W) - 1;
  localparam logic [DAC_W-1:0] MID = DAC_W'(1 << MAG_W);

  logic [MAG_W-1:0] qrom [QN];

  // quarter-wave table sampled at half-step points so mirroring needs no extra entry
  initial begin
    for (int k = 0; k < QN; k++) begin
      real ang;
      ang = 2.0 * 3.141592653589793 * (real'(k) + 0.5) / real'(4 * QN);
      qrom[k] = MAG_W'($rtoi(real'(AMP) * $sin(ang) + 0.5));
    end
  end

  logic [QA_W-1:0]  raddr;
  logic [MAG_W-1:0] mag_q;
  logic             neg_q;
  logic             vld_q;

  always_comb raddr = phase[QA_W-1:0] ^ {QA_W{phase[PH_W-2]}};

  // table read without reset so it maps onto block RAM
  always_ff @(posedge clk) mag_q <= qrom[raddr];

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q    <= 1'b0;
      vld_q    <= 1'b0;
      dac_code <= MID;
    end else begin
      neg_q <= phase[PH_W-1];
      vld_q <= run;
      if (!vld_q)     dac_code <= MID;
      else if (neg_q) dac_code <= MID - {1'b0, mag_q};
      else            dac_code <= MID + {1'b0, mag_q};
    end
  end
endmodule

// File: rtl/sine_sync_dds.sv
`timescale 1ns/1ps
module sine_sync_dds #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 10,
  parameter int DAC_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [ACC_W-1:0] cfg_wdata,
  input  logic             sync_in,
  output logic [DAC_W-1:0] dac_code
);
  logic [ACC_W-1:0] tune_pend, offs, acc, tune_act;
  logic             run, sync_rise, wrap;

  sdds_regs #(.ACC_W(ACC_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .tune_pend(tune_pend), .offs(offs), .run(run)
  );

  sdds_phase #(.ACC_W(ACC_W)) u_phase (
    .clk(clk), .rst(rst), .run(run), .sync_in(sync_in),
    .tune_pend(tune_pend), .offs(offs),
    .acc(acc), .tune_act(tune_act), .sync_rise(sync_rise), .wrap(wrap)
  );

  sdds_lut #(.PH_W(PH_W), .DAC_W(DAC_W)) u_lut (
    .clk(clk), .rst(rst), .run(run),
    .phase(acc[ACC_W-1 -: PH_W]), .dac_code(dac_code)
  );
endmodule

// File: rtl/sdds_chk.sv
`timescale 1ns/1ps
module sdds_chk #(
  parameter int ACC_W = 32,
  parameter int DAC_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             sync_rise,
  input logic             wrap,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] tune_act,
  input logic [ACC_W-1:0] offs,
  input logic [DAC_W-1:0] dac_code
);
  localparam logic [DAC_W-1:0] MID = DAC_W'(1 << (DAC_W - 1));

  a_r1_reset_mid: assert property (@(posedge clk) rst |=> (dac_code == MID));

  a_r2_off_mid: assert property (@(posedge clk) disable iff (rst)
    !run |=> ##1 (dac_code == MID));

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (run && !sync_rise) |=> (acc == $past(acc) + $past(tune_act)));

  a_r4_range: assert property (@(posedge clk) disable iff (rst)
    dac_code != '0);

  a_r5_sync_load: assert property (@(posedge clk) disable iff (rst)
    (run && sync_rise) |=> (acc == $past(offs)));

  a_r6_tune_hold: assert property (@(posedge clk) disable iff (rst)
    (run && !sync_rise && !wrap) |=> $stable(tune_act));
endmodule

bind sine_sync_dds sdds_chk #(.ACC_W(ACC_W), .DAC_W(DAC_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .sync_rise(sync_rise), .wrap(wrap),
  .acc(acc), .tune_act(tune_act), .offs(offs), .dac_code(dac_code)
);

// File: tb/sim_sine_sync_dds.sv
`timescale 1ns/1ps
module sim_sine_sync_dds;
  localparam logic [13:0] MID = 14'h2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        sync_in = 1'b0;
  logic [13:0] dac_code;

  always #2 clk = ~clk;

  sine_sync_dds u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sync_in(sync_in), .dac_code(dac_code)
  );

  typedef struct {
    int          due;
    logic [13:0] code;
    string       tag;
  } item_t;

  item_t q[$];
  int    checks = 0, fails = 0, cyc = 0;
  bit    done = 0;
  bit    fc_on = 0;
  int    xings = 0;
  logic [13:0] prev_code = MID;
  string cur_tag = "R3";

  // requirement-level model state
  logic [31:0] m_acc = '0, m_act = '0, m_pend = '0, m_offs = '0;
  logic        m_run = 0, m_syncd = 0, s_lvl = 0;

  function automatic logic [13:0] ref_code(input logic [9:0] p);
    real a;
    int  r;
    a = 8191.0 * $sin(2.0 * 3.141592653589793 * (real'(p) + 0.5) / 1024.0);
    if (a >= 0.0) r = $rtoi(a + 0.5);
    else          r = -$rtoi(-a + 0.5);
    return 14'(8192 + r);
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected sample
  task automatic tick(input logic we, input logic [1:0] a, input logic [31:0] d);
    logic        edge_s;
    logic [32:0] sum;
    item_t       it;
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = d; sync_in = s_lvl;
    edge_s = s_lvl & ~m_syncd;
    sum = {1'b0, m_acc} + {1'b0, m_act};
    if (!m_run || edge_s) begin
      m_acc = m_offs; m_act = m_pend;
    end else begin
      m_acc = sum[31:0];
      if (sum[32]) m_act = m_pend;
    end
    m_syncd = s_lvl;
    if (we) begin
      case (a)
        2'd0: m_pend = d;
        2'd1: m_offs = d;
        2'd2: m_run  = d[0];
        default: ;
      endcase
    end
    it.due  = cyc + 3;
    it.code = m_run ? ref_code(m_acc[31:22]) : MID;
    it.tag  = cur_tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 2'd0, 32'd0);
  endtask

  // monitor: compares each sample against the scoreboard
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      while (q.size() > 0 && q[0].due <= cyc) begin
        it = q.pop_front();
        if (it.due == cyc) check(it.tag, 32'(dac_code), 32'(it.code));
      end
      if (fc_on && prev_code < MID && dac_code >= MID) xings++;
      prev_code = dac_code;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    longint exp_x;
    repeat (4) @(posedge clk);
    #1;
    check("R1", 32'(dac_code), 32'(MID));
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", 32'(dac_code), 32'(MID));

    // R8 register writes, R2 disabled output
    cur_tag = "R2";
    tick(1'b1, 2'd1, 32'h0000_0000);
    tick(1'b1, 2'd0, 32'd107374182);
    idle(5);
    // R9 enable start
    cur_tag = "R9";
    tick(1'b1, 2'd2, 32'd1);
    idle(3);
    cur_tag = "R3";
    idle(120);

    // R7 frequency over a fixed window
    cur_tag = "R7";
    xings = 0; fc_on = 1;
    idle(4000);
    fc_on = 0;
    exp_x = (longint'(107374182) * 4000) >>> 32;
    checks++;
    if (longint'(xings) > exp_x + 1 || longint'(xings) < exp_x - 1) begin
      fails++;
      $display("FAIL R7: got %0d crossings expected %0d", xings, exp_x);
    end

    // R5 sync realignment, level and falling edge have no effect
    cur_tag = "R8";
    tick(1'b1, 2'd1, 32'h6000_0000);
    cur_tag = "R5";
    s_lvl = 1; idle(20);
    s_lvl = 0; idle(30);
    tick(1'b1, 2'd1, 32'hC123_4567);
    s_lvl = 1; idle(3);
    s_lvl = 0; idle(40);

    // R6 staged tuning word applies at wrap
    cur_tag = "R6";
    tick(1'b1, 2'd0, 32'h0800_0000);
    idle(200);
    tick(1'b1, 2'd0, 32'h0100_0000);
    idle(7);
    s_lvl = 1; idle(2);
    s_lvl = 0; idle(60);

    // R8 address 3 ignored
    cur_tag = "R8";
    tick(1'b1, 2'd3, 32'hFFFF_FFFF);
    idle(50);

    // R4 full sweep, one table step per clock
    cur_tag = "R4";
    tick(1'b1, 2'd0, 32'h0040_0000);
    tick(1'b1, 2'd1, 32'h0000_0000);
    s_lvl = 1; idle(1);
    s_lvl = 0; idle(1100);

    // R2 disable then R9 re-enable from offset
    cur_tag = "R2";
    tick(1'b1, 2'd2, 32'd0);
    tick(1'b1, 2'd1, 32'h3FC0_0000);
    idle(20);
    cur_tag = "R9";
    tick(1'b1, 2'd2, 32'd1);
    idle(40);

    idle(5);
    done = 1;
    summary();
    $finish;
  end
endmodule